// File: doc/BRIEF.md
# CompactFlash sector read sequencer

This block reads a run of 512-byte sectors from a CompactFlash card through the 16-bit register window of a card configuration controller. It does in hardware the job a boot-time software driver would otherwise do. A single start command carries a 28-bit logical block address and a sector count. The block then runs the whole sequence on its own: it takes the controller lock, waits for the card to be ready for a command, and issues read commands in chunks of at most 256 sectors. It drains the controller's data buffer in 16-word bursts and delivers the bytes on a valid/ready stream. When it finishes, it releases the lock and pulses `done` with an error code.

The register bus is a plain request/acknowledge interface. A strobe and its address are held until `bus_ack` is seen at a clock edge. On a controller wired with an 8-bit data bus, each 16-bit register access is split into two byte accesses at the even offset and the following odd offset. A parameter decides which half of the word goes first. The spacing of the lock and ready polls is derived from a clock-frequency parameter, so the wall-clock intervals stay near 100 ms and 1 ms.

Top module: `cf_sector_reader`

## Requirements
- R1: After reset, before becoming idle, the block performs exactly one write to the mode register at offset 0x00. The value is 0 when BUS8 is set (8-bit device bus) and 1 otherwise.
- R2: To take the lock, the block reads the control register (0x18) and writes it back with bit 1 set, leaving the other bits unchanged. It then reads status (0x04) until bit 1 is set. After LOCK_POLLS failing polls, spaced CLK_HZ/10 cycles apart, it fails with code 2, or with code 1 if status bit 4 (card present) is clear.
- R3: Once the lock is held, the block polls status bit 8 (ready for command), spaced CLK_HZ/1000 cycles apart. Status bit 4 clear on any such poll ends the transfer with code 1. After READY_POLLS polls without readiness, the transfer ends with code 3.
- R4: For each chunk, the block writes address bits 15:0 to offset 0x10, then writes bits 27:16 to offset 0x12 with bits 15:12 of that word zero.
- R5: Each chunk covers min(256, remaining) sectors. The command word written to offset 0x14 holds the chunk size in bits 7:0, where 0 means 256, and holds 3 in bits 9:8; bits 15:10 are zero. The next chunk starts at the previous address plus the chunk size.
- R6: After each command word, the block sets control bit 7 with a read-modify-write before any data read. It clears bit 7 again after the chunk's last data word.
- R7: The block reads the data register (0x40) only after a status read has shown bit 5 (buffer ready). Each such status read is followed by exactly 16 data reads.
- R8: Each data word appears on the byte stream as its low byte and then its high byte. A good transfer delivers exactly SECTOR_BYTES × count bytes in address order, and no byte is offered while idle.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values, and no byte is lost.
- R10: At the end of every transfer that took the lock path, good or failed, control bit 1 is cleared with a read-modify-write.
- R11: `done` is a one-cycle pulse raised as the block returns to idle. `err` then reads 0 for success, 1 for card absent, 2 for lock timeout and 3 for not ready. A count of 0 completes at once with code 0 and no bus access.
- R12: `start` is acted on only while `idle` is high. A start raised during a transfer changes neither its data nor its completion.
- R13: With BUS8 set, each register access is two byte accesses at the even offset and then offset+1. HI_FIRST=1 puts bits 15:8 in the first access. Write data bits 15:8 are zero, and a strobe with its address holds until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a transfer (taken only when idle) |
| start_lba | input | 28 | First logical block address |
| start_count | input | CNT_W | Number of sectors to read |
| idle | output | 1 | Ready to accept a start |
| done | output | 1 | One-cycle completion pulse |
| err | output | 2 | Completion code, valid with done |
| bus_addr | output | 7 | Register byte offset |
| bus_rd | output | 1 | Read strobe, held until ack |
| bus_wr | output | 1 | Write strobe, held until ack |
| bus_wdata | output | 16 | Write data (low byte only on an 8-bit bus) |
| bus_rdata | input | 16 | Read data, taken with ack |
| bus_ack | input | 1 | Access complete at this edge |
| out_data | output | 8 | Sector byte |
| out_valid | output | 1 | Byte available |
| out_ready | input | 1 | Consumer accepts byte |

## Verification
A wrong sequencer state shows up on the register bus within a few accesses. The device model sees a misplaced address word, a bad command field or a data read without the buffer-ready or reset bit, and flags it as soon as that access is acknowledged. A wrong word or byte counter shifts the stream, so the next byte fails against the content computed from the address. A wrong poll counter or error branch shows only at `done`, through the error code, the number of status polls and the final state of the control bits.

// File: rtl/cf_sector_reader.sv
module cf_sector_reader #(
  parameter int BUS8         = 0,
  parameter int HI_FIRST     = 1,
  parameter int CLK_HZ       = 100_000_000,
  parameter int LOCK_POLLS   = 10,
  parameter int READY_POLLS  = 2000,
  parameter int SECTOR_BYTES = 512,
  parameter int CNT_W        = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [27:0]      start_lba,
  input  logic [CNT_W-1:0] start_count,
  output logic             idle,
  output logic             done,
  output logic [1:0]       err,
  output logic [6:0]       bus_addr,
  output logic             bus_rd,
  output logic             bus_wr,
  output logic [15:0]      bus_wdata,
  input  logic [15:0]      bus_rdata,
  input  logic             bus_ack,
  output logic [7:0]       out_data,
  output logic             out_valid,
  input  logic             out_ready
);
  localparam int LOCK_GAP  = (CLK_HZ / 10 > 1) ? CLK_HZ / 10 : 1;
  localparam int READY_GAP = (CLK_HZ / 1000 > 1) ? CLK_HZ / 1000 : 1;
  localparam int GAP_W     = $clog2(LOCK_GAP + 1);
  localparam int MAXP      = (LOCK_POLLS > READY_POLLS) ? LOCK_POLLS : READY_POLLS;
  localparam int POLL_W    = $clog2(MAXP + 1);
  localparam int BPS       = SECTOR_BYTES / 32;
  localparam int BC_W      = $clog2(256 * BPS + 1);

  localparam logic [6:0] A_MODE = 7'h00, A_STAT = 7'h04, A_ALO = 7'h10, A_AHI = 7'h12,
                         A_CMD = 7'h14, A_CTRL = 7'h18, A_DATA = 7'h40;

  typedef enum logic [4:0] {
    S_INIT, S_IDLE, S_ACC, S_WAIT,
    S_LK_SET, S_LK_POLL, S_LK_CHK,
    S_RDY_POLL, S_RDY_CHK,
    S_ADR_LO, S_ADR_HI, S_CMD, S_RST_RD, S_RST_SET,
    S_BUF_POLL, S_BUF_CHK, S_DATA, S_EMIT_LO, S_EMIT_HI,
    S_CLR_RD, S_CLR_WR, S_NEXT, S_REL_RD, S_REL_WR, S_FIN
  } state_t;

  state_t             state, ret;
  logic               phase;
  logic [6:0]         acc_addr;
  logic               acc_wr;
  logic [15:0]        acc_wd, word;
  logic [7:0]         hold;
  logic [27:0]        lba;
  logic [CNT_W-1:0]   rem;
  logic [8:0]         chunk;
  logic [POLL_W-1:0]  pcnt;
  logic [GAP_W-1:0]   gap;
  logic [BC_W-1:0]    bcnt;
  logic [3:0]         wcnt;
  logic               sel_hi;
  logic [15:0]        rd_word;

  assign sel_hi    = phase ^ (HI_FIRST != 0);
  assign bus_addr  = acc_addr | {6'd0, (BUS8 != 0) && phase};
  assign bus_wdata = (BUS8 != 0) ? {8'h00, sel_hi ? acc_wd[15:8] : acc_wd[7:0]} : acc_wd;
  assign rd_word   = (BUS8 == 0)    ? bus_rdata :
                     (HI_FIRST != 0) ? {hold, bus_rdata[7:0]} : {bus_rdata[7:0], hold};
  assign bus_rd    = (state == S_ACC) && !acc_wr;
  assign bus_wr    = (state == S_ACC) && acc_wr;
  assign out_valid = (state == S_EMIT_LO) || (state == S_EMIT_HI);
  assign out_data  = (state == S_EMIT_HI) ? word[15:8] : word[7:0];
  assign idle      = (state == S_IDLE);

  task automatic issue(input logic [6:0] a, input logic w, input logic [15:0] d, input state_t r);
    acc_addr <= a;
    acc_wr   <= w;
    acc_wd   <= d;
    ret      <= r;
    phase    <= 1'b0;
    state    <= S_ACC;
  endtask

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_INIT; ret <= S_IDLE; phase <= 1'b0;
      acc_addr <= '0; acc_wr <= 1'b0; acc_wd <= '0; word <= '0; hold <= '0;
      lba <= '0; rem <= '0; chunk <= '0; pcnt <= '0; gap <= '0; bcnt <= '0; wcnt <= '0;
      done <= 1'b0; err <= 2'd0;
    end else begin
      done <= 1'b0;
      case (state)
        S_INIT: issue(A_MODE, 1'b1, (BUS8 != 0) ? 16'h0000 : 16'h0001, S_IDLE);
        S_IDLE:
          if (start) begin
            err <= 2'd0;
            lba <= start_lba;
            rem <= start_count;
            if (start_count == '0) done <= 1'b1;
            else issue(A_CTRL, 1'b0, 16'h0000, S_LK_SET);
          end
        S_ACC:
          if (bus_ack) begin
            if ((BUS8 != 0) && !phase) begin
              hold  <= bus_rdata[7:0];
              phase <= 1'b1;
            end else begin
              if (!acc_wr) word <= rd_word;
              phase <= 1'b0;
              state <= ret;
            end
          end
        S_WAIT:
          if (gap == '0) state <= ret;
          else gap <= gap - 1'b1;
        S_LK_SET: begin
          pcnt <= '0;
          issue(A_CTRL, 1'b1, word | 16'h0002, S_LK_POLL);
        end
        S_LK_POLL: issue(A_STAT, 1'b0, 16'h0000, S_LK_CHK);
        S_LK_CHK:
          if (word[1]) begin
            pcnt  <= '0;
            state <= S_RDY_POLL;
          end else if (pcnt == POLL_W'(LOCK_POLLS - 1)) begin
            err   <= word[4] ? 2'd2 : 2'd1;
            state <= S_REL_RD;
          end else begin
            pcnt  <= pcnt + 1'b1;
            gap   <= GAP_W'(LOCK_GAP - 1);
            ret   <= S_LK_POLL;
            state <= S_WAIT;
          end
        S_RDY_POLL: issue(A_STAT, 1'b0, 16'h0000, S_RDY_CHK);
        S_RDY_CHK:
          if (!word[4]) begin
            err   <= 2'd1;
            state <= S_REL_RD;
          end else if (word[8]) begin
            state <= S_ADR_LO;
          end else if (pcnt == POLL_W'(READY_POLLS - 1)) begin
            err   <= 2'd3;
            state <= S_REL_RD;
          end else begin
            pcnt  <= pcnt + 1'b1;
            gap   <= GAP_W'(READY_GAP - 1);
            ret   <= S_RDY_POLL;
            state <= S_WAIT;
          end
        S_ADR_LO: begin
          chunk <= (rem > CNT_W'(256)) ? 9'd256 : rem[8:0];
          issue(A_ALO, 1'b1, lba[15:0], S_ADR_HI);
        end
        S_ADR_HI: issue(A_AHI, 1'b1, {4'h0, lba[27:16]}, S_CMD);
        S_CMD:    issue(A_CMD, 1'b1, {6'd0, 2'b11, chunk[7:0]}, S_RST_RD);
        S_RST_RD: issue(A_CTRL, 1'b0, 16'h0000, S_RST_SET);
        S_RST_SET: begin
          bcnt <= BC_W'(chunk) * BC_W'(BPS);
          issue(A_CTRL, 1'b1, word | 16'h0080, S_BUF_POLL);
        end
        S_BUF_POLL: issue(A_STAT, 1'b0, 16'h0000, S_BUF_CHK);
        S_BUF_CHK:
          if (word[5]) begin
            wcnt  <= '0;
            state <= S_DATA;
          end else state <= S_BUF_POLL;
        S_DATA:    issue(A_DATA, 1'b0, 16'h0000, S_EMIT_LO);
        S_EMIT_LO: if (out_ready) state <= S_EMIT_HI;
        S_EMIT_HI:
          if (out_ready) begin
            wcnt <= wcnt + 1'b1;
            if (wcnt == 4'hF) begin
              bcnt  <= bcnt - 1'b1;
              state <= (bcnt == BC_W'(1)) ? S_CLR_RD : S_BUF_POLL;
            end else state <= S_DATA;
          end
        S_CLR_RD: issue(A_CTRL, 1'b0, 16'h0000, S_CLR_WR);
        S_CLR_WR: issue(A_CTRL, 1'b1, word & 16'hFF7F, S_NEXT);
        S_NEXT: begin
          lba   <= lba + 28'(chunk);
          rem   <= rem - CNT_W'(chunk);
          state <= (rem == CNT_W'(chunk)) ? S_REL_RD : S_ADR_LO;
        end
        S_REL_RD: issue(A_CTRL, 1'b0, 16'h0000, S_REL_WR);
        S_REL_WR: issue(A_CTRL, 1'b1, word & 16'hFFFD, S_FIN);
        S_FIN: begin
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cf_sector_reader_chk.sv
module cf_sector_reader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       idle,
  input logic       done,
  input logic [6:0] bus_addr,
  input logic       bus_rd,
  input logic       bus_wr,
  input logic       bus_ack,
  input logic [7:0] out_data,
  input logic       out_valid,
  input logic       out_ready
);
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr)); // R13
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !bus_ack |=> bus_rd && $stable(bus_addr)); // R13
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !bus_ack |=> bus_wr && $stable(bus_addr)); // R13
  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R9
  AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> idle); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !out_valid && !bus_rd && !bus_wr); // R12
endmodule

bind cf_sector_reader cf_sector_reader_chk chk_i (
  .clk(clk), .rst_n(rst_n), .idle(idle), .done(done), .bus_addr(bus_addr),
  .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_ack(bus_ack), .out_data(out_data),
  .out_valid(out_valid), .out_ready(out_ready)
);

// File: tb/cf_sector_reader_tb.sv
`timescale 1ns/1ps
module cf_sector_reader_tb_top;
  localparam int SB = 32, LP = 10, RP = 2000, HZ = 4000;
  localparam int LGAP = HZ / 10, RGAP = HZ / 1000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [27:0] start_lba = '0;
  logic [15:0] start_count = '0;
  logic idle, done, bus_rd, bus_wr, out_valid;
  logic [1:0] err;
  logic [6:0] bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata = '0;
  logic bus_ack = 1'b0, out_ready = 1'b0;
  logic [7:0] out_data;

  always #2 clk = ~clk;

  cf_sector_reader #(.BUS8(1), .HI_FIRST(1), .CLK_HZ(HZ), .LOCK_POLLS(LP), .READY_POLLS(RP),
                     .SECTOR_BYTES(SB), .CNT_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_lba(start_lba), .start_count(start_count),
    .idle(idle), .done(done), .err(err), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack), .out_data(out_data),
    .out_valid(out_valid), .out_ready(out_ready));

  int n_chk = 0, n_bad = 0, cyc = 0;
  always @(posedge clk) cyc++;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] hash(input logic [27:0] l, input int w);
    logic [31:0] x;
    x = ({4'h0, l} * 32'd2654435761) ^ (32'(w) * 32'h9E37 + 32'h5A5A);
    return x[31:16] ^ x[15:0];
  endfunction

  function automatic logic [7:0] exp_byte(input logic [27:0] base, input int idx);
    logic [15:0] h;
    h = hash(base + 28'(idx / SB), (idx % SB) / 2);
    return (idx % 2) ? h[15:8] : h[7:0];
  endfunction

  // environment set by the main sequence only
  bit grant_en = 1, card = 1, rdy_en = 1, bp_on = 1;
  logic [27:0] x_base = '0;
  int x_cnt = 0, x_id = 0;

  // device model state, written by the model only
  logic [15:0] r_mode = '0, r_ctrl = '0, r_lba0 = '0, r_lba1 = '0;
  logic [7:0] stage = '0, lohold = '0;
  bit bufrdy = 0;
  int bw = 0, cur_w = 0, stat_reads = 0, n_wr = 0, mode_wr = 0, viol = 0, hi_nz = 0;
  int prog = 0, m_id = 0;
  logic [27:0] cur_lba = '0;

  task automatic dev_write(input logic [6:0] wa, input logic [15:0] v);
    int ch;
    case (wa)
      7'h00: begin r_mode = v; mode_wr++; end
      7'h10: r_lba0 = v;
      7'h12: r_lba1 = v;
      7'h18: r_ctrl = v;
      7'h14: begin
        ch = (x_cnt - prog > 256) ? 256 : x_cnt - prog;
        check("R5 command word", 32'(v), {22'd0, 2'b11, 8'(ch)});
        check("R4 address low word", 32'(r_lba0), 32'((x_base + 28'(prog)) & 28'hFFFF));
        check("R4 address high word", 32'(r_lba1), 32'((x_base + 28'(prog)) >> 16));
        cur_lba = {r_lba1[11:0], r_lba0};
        cur_w = 0; bw = 0; bufrdy = 0;
        prog += ch;
      end
      default: ;
    endcase
  endtask

  task automatic dev_read(input logic [6:0] wa, output logic [15:0] w);
    w = '0;
    case (wa)
      7'h04: begin
        stat_reads++;
        w[1] = r_ctrl[1] & grant_en;
        w[4] = card;
        w[5] = bufrdy;
        w[8] = rdy_en;
      end
      7'h18: w = r_ctrl;
      7'h40: begin
        if (!bufrdy || !r_ctrl[7]) viol++;
        w = hash(cur_lba + 28'(cur_w / 16), cur_w % 16);
        cur_w++; bw++;
        if (bw == 16) begin bw = 0; bufrdy = 0; end
      end
      default: ;
    endcase
  endtask

  always @(negedge clk) begin
    logic [6:0] wa;
    logic [15:0] w;
    if (m_id != x_id) begin m_id = x_id; prog = 0; end
    bus_ack = 1'b0;
    if (!bufrdy && r_ctrl[7] && ($urandom % 3 == 0)) bufrdy = 1;
    if ((bus_rd || bus_wr) && ($urandom % 3 != 0)) begin
      bus_ack = 1'b1;
      wa = {bus_addr[6:1], 1'b0};
      if (bus_wr) begin
        n_wr++;
        if (bus_wdata[15:8] != 8'h00) hi_nz++;
        if (!bus_addr[0]) stage = bus_wdata[7:0];
        else dev_write(wa, {stage, bus_wdata[7:0]});
      end else if (!bus_addr[0]) begin
        dev_read(wa, w);
        bus_rdata = {8'h00, w[15:8]};
        lohold = w[7:0];
      end else bus_rdata = {8'h00, lohold};
    end
  end

  // stream consumer
  int sidx = 0, s_id = 0, dones = 0;
  bit hv = 0;
  logic [7:0] hd = '0;
  always @(negedge clk) begin
    if (s_id != x_id) begin s_id = x_id; sidx = 0; end
    if (rst_n) begin
      if (hv) begin
        check("R9 valid held", 32'(out_valid), 32'd1);
        check("R9 data held", 32'(out_data), 32'(hd));
      end
      out_ready = bp_on ? ($urandom % 4 != 0) : 1'b1;
      if (out_valid && out_ready) begin
        check("R8 stream byte", 32'(out_data), 32'(exp_byte(x_base, sidx)));
        sidx++;
      end
      hv = out_valid && !out_ready;
      hd = out_data;
      if (done) dones++;
    end
  end

  int elapsed = 0;
  task automatic run(input logic [27:0] l, input int cnt, input bit g, input bit c, input bit r,
                     input int e_err, input bit poke);
    int d0, t0;
    while (!idle) @(negedge clk);
    grant_en = g; card = c; rdy_en = r;
    x_base = l; x_cnt = cnt; x_id++;
    @(negedge clk);
    d0 = dones;
    start = 1'b1; start_lba = l; start_count = 16'(cnt); t0 = cyc;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (40) @(negedge clk);
      start = 1'b1; start_lba = l + 28'h123; start_count = 16'd2;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    elapsed = cyc - t0;
    check("R11 error code", 32'(err), 32'(e_err));
    check("R8 byte total", 32'(sidx), (e_err == 0) ? 32'(cnt * SB) : 32'd0);
    if (cnt > 0) begin
      check("R10 lock bit released", 32'(r_ctrl[1]), 32'd0);
      check("R6 reset bit cleared", 32'(r_ctrl[7]), 32'd0);
    end
    if (e_err == 0) check("R5 sectors commanded", 32'(prog), 32'(cnt));
    repeat (5) @(negedge clk);
    check("R12 single completion", 32'(dones - d0), 32'd1);
  endtask

  initial begin
    int w0, s0;
    void'($urandom(32'd7319));
    repeat (3) @(negedge clk);
    check("R11 reset done low", 32'(done), 32'd0);
    check("R8 reset valid low", 32'(out_valid), 32'd0);
    check("R13 reset strobes low", 32'({bus_rd, bus_wr}), 32'd0);
    rst_n = 1'b1;
    while (!idle) @(negedge clk);
    check("R1 mode write count", 32'(mode_wr), 32'd1);
    check("R1 mode value", 32'(r_mode), 32'd0);
    check("R13 two byte writes", 32'(n_wr), 32'd2);

    run(28'd0, 1, 1, 1, 1, 0, 0);
    run(28'h0FFF_FFF0, 3, 1, 1, 1, 0, 0);
    w0 = n_wr;
    run(28'h0000_1234, 0, 1, 1, 1, 0, 0);
    check("R11 zero count no bus", 32'(n_wr - w0), 32'd0);
    for (int i = 0; i < 6; i++) begin
      bp_on = (i % 2 == 0);
      run(28'($urandom), 1 + int'($urandom % 4), 1, 1, 1, 0, 0);
    end
    bp_on = 1;
    run(28'h0ABC_DEF0, 257, 1, 1, 1, 0, 1);

    s0 = stat_reads;
    run(28'h0000_0100, 2, 1, 0, 1, 1, 0);
    check("R3 absent on first ready poll", 32'(stat_reads - s0), 32'd2);
    s0 = stat_reads;
    run(28'h0000_0200, 2, 0, 1, 1, 2, 0);
    check("R2 lock poll count", 32'(stat_reads - s0), 32'(LP));
    check("R2 lock poll spacing", 32'(elapsed >= (LP - 1) * LGAP), 32'd1);
    s0 = stat_reads;
    run(28'h0000_0300, 2, 0, 0, 1, 1, 0);
    check("R2 lock timeout with card absent", 32'(stat_reads - s0), 32'(LP));
    s0 = stat_reads;
    run(28'h0000_0400, 2, 1, 1, 0, 3, 0);
    check("R3 ready poll count", 32'(stat_reads - s0), 32'(1 + RP));
    check("R3 ready poll spacing", 32'(elapsed >= (RP - 1) * RGAP), 32'd1);

    check("R7 data reads gated", 32'(viol), 32'd0);
    check("R13 write upper byte zero", 32'(hi_nz), 32'd0);
    check("R1 single mode write", 32'(mode_wr), 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule